// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block turns single access requests from an internal master into cycles on a shared address/data bus. Each request carries an address, a write flag, a size (byte or 16-bit word) and write data. The address is compared against three programmable windows. The first window that matches supplies the timing and width settings for the whole access. An address that matches no window is rejected with an error response, and no bus cycle is run.

Each bus cycle has two parts. In the address phase the address is driven on the shared lines while the latch strobe is high. In the data phase the read or write strobe is active, and for reads the shared lines are turned around to input. A window can use a 2-state or a 3-state cycle. A 3-state window can add one programmed wait to the address phase and up to three to the data phase. In one wait mode it can also hold the last data wait for as long as an external wait line is asserted. These waits stretch every access in the window, whichever master issued it.

A word access to an 8-bit window is carried out as two complete byte cycles. Requests use a valid/ready handshake: `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. A master that holds `req_valid` while `req_ready` is low simply waits. The response is a one-cycle pulse with no back-pressure, so the master must accept it when it appears.

Top module: `mux_bus_ctrl`

## Requirements
- R1: An address hits window i when `(addr ^ base_i) & mask_i` is zero. The lowest-numbered hitting window wins. A request that hits no window produces `rsp_valid` and `rsp_err` high for one cycle, in the cycle after acceptance, and no bus strobe is asserted.
- R2: A window configured as 2-state runs exactly one address state and one data state per bus cycle. Its wait mode, address-wait and data-wait settings have no effect.
- R3: In a 3-state window with program waits enabled, the address phase lasts 1 + `awt` states and the data phase lasts 2 + `dwt` states (`awt` 0..1, `dwt` 0..3).
- R4: The wait mode is a 2-bit field: 0 = no waits, 1 = program waits, 2 = program waits plus the external wait line, 3 = behaves as 0. In modes 0 and 3 a 3-state window inserts no waits.
- R5: In mode 2 with `dwt` > 0, `bus_ext_wait` is sampled only in the last programmed data wait, and that wait repeats while the line is high. With `dwt` = 0, or in any other mode, the line has no effect.
- R6: `bus_as` is high through the whole address phase and only then, and `bus_ad_out` carries the address during that time. `bus_rd`/`bus_wr` are active only in data states, never together, and the data phase starts in the state right after the address phase.
- R7: During a read data phase `bus_ad_oe` is low. During a write data phase `bus_ad_oe` is high and the write data is driven.
- R8: In a 16-bit window a word uses all 16 lines, a byte at an even address uses lines 15:8 and a byte at an odd address uses lines 7:0. In an 8-bit window data always uses lines 7:0. A byte write takes its value from `req_wdata[7:0]`.
- R9: A word access to an 8-bit window runs two full bus cycles: first the even address with data bits 15:8, then the odd address with bits 7:0. There is one response after the second cycle, and read data is assembled as {first byte, second byte}.
- R10: A word access ignores address bit 0 and uses the even address.
- R11: `req_ready` is high only while idle. The response pulse comes in the state after the final data state. `rsp_rdata` holds the read value (a byte zero-extended into bits 7:0), and it is zero for writes.
- R12: The window settings are captured when a request is accepted. Changes to the settings during an access do not affect that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was an address miss |
| rsp_rdata | output | DATA_W | Read result |
| cfg_base | input | NUM_AREAS*ADDR_W | Window base addresses, window i at bits i*ADDR_W |
| cfg_mask | input | NUM_AREAS*ADDR_W | Window compare masks |
| cfg_wide | input | NUM_AREAS | 1 = 16-bit window |
| cfg_three | input | NUM_AREAS | 1 = 3-state window |
| cfg_wmode | input | 2*NUM_AREAS | Wait mode per window |
| cfg_awt | input | NUM_AREAS | Address-phase program wait |
| cfg_dwt | input | 2*NUM_AREAS | Data-phase program waits |
| bus_ad_out | output | DATA_W | Shared lines, driven value |
| bus_ad_oe | output | 1 | Shared lines output enable |
| bus_ad_in | input | DATA_W | Shared lines, sampled value |
| bus_as | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ext_wait | input | 1 | External wait request |

## Verification
The first address state appears in the cycle right after the accepting edge. A miss response also appears in that cycle. The data strobes follow in the state right after the last address state. The response pulse comes exactly one cycle after the final data state, and the read value is captured at the edge that ends that state. The bench model takes this timing from the requirements: it turns each accepted request into a queue of per-cycle pin expectations, inserting extra waits according to the external wait level it drives in each cycle. It then compares the queue against the design on every falling clock edge, so every strobe, enable, lane value and response is checked in the exact cycle it is due.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  localparam logic [1:0] WM_PROG = 2'd1;
  localparam logic [1:0] WM_EXT  = 2'd2;

  typedef struct packed {
    logic       wide;
    logic       three;
    logic [1:0] wmode;
    logic       awt;
    logic [1:0] dwt;
  } area_cfg_t;

  typedef struct packed {
    logic       wide;
    logic       three;
    logic       awt;
    logic [1:0] dwt;
    logic       ext_en;
  } eff_timing_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AWAIT, S_DSTART, S_DWAIT, S_DEND
  } seq_state_t;

  // Collapse raw settings into the timing actually applied.
  function automatic eff_timing_t resolve_timing(area_cfg_t c);
    eff_timing_t r;
    logic        prog;
    prog     = c.three && (c.wmode == WM_PROG || c.wmode == WM_EXT);
    r.wide   = c.wide;
    r.three  = c.three;
    r.awt    = prog & c.awt;
    r.dwt    = prog ? c.dwt : 2'd0;
    r.ext_en = c.three && (c.wmode == WM_EXT);
    return r;
  endfunction

endpackage

// File: rtl/mbc_area_decode.sv
module mbc_area_decode #(
  parameter int N  = 3,
  parameter int AW = 16,
  parameter int IW = 2
) (
  input  logic [AW-1:0]   addr,
  input  logic [N*AW-1:0] base,
  input  logic [N*AW-1:0] mask,
  output logic            hit,
  output logic [IW-1:0]   idx
);

  logic [N-1:0] match;

  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = ((addr ^ base[g*AW +: AW]) & mask[g*AW +: AW]) == '0;
    end
  endgenerate

  // Lowest index wins: scan downwards so the last assignment is the lowest.
  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/mbc_lane_map.sv
module mbc_lane_map #(
  parameter int DW = 16
) (
  input  logic          wide,
  input  logic          word,
  input  logic          sub,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] drive,
  output logic [DW-1:0] pick
);

  localparam int H = DW / 2;

  always_comb begin
    if (wide) begin
      if (word)    drive = wdata;
      else if (a0) drive = {{H{1'b0}}, wdata[H-1:0]};
      else         drive = {wdata[H-1:0], {H{1'b0}}};
    end else begin
      drive = {{H{1'b0}}, (word && !sub) ? wdata[DW-1:H] : wdata[H-1:0]};
    end
  end

  always_comb begin
    if (wide && word)  pick = bus_in;
    else if (wide)     pick = {{H{1'b0}}, a0 ? bus_in[H-1:0] : bus_in[DW-1:H]};
    else               pick = {{H{1'b0}}, bus_in[H-1:0]};
  end

endmodule

// File: rtl/mbc_cycle_seq.sv
module mbc_cycle_seq
  import mbc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [DW-1:0] req_wdata,
  input  logic          area_hit,
  input  eff_timing_t   sel_timing,
  input  logic          ext_wait,
  input  logic [DW-1:0] lane_pick,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          cur_word,
  output logic          cur_wide,
  output logic          cur_sub,
  output logic [DW-1:0] cur_wdata,
  output logic          as_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          oe_o
);

  localparam int H = DW / 2;

  seq_state_t    st;
  eff_timing_t   tim;
  logic [AW-1:0] addr_q;
  logic          write_q;
  logic          word_q;
  logic [DW-1:0] wdata_q;
  logic          sub_q;
  logic [1:0]    wcnt;
  logic [H-1:0]  hi_q;
  logic          split;
  logic          in_data;

  assign split = word_q && !tim.wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tim       <= '0;
      addr_q    <= '0;
      write_q   <= 1'b0;
      word_q    <= 1'b0;
      wdata_q   <= '0;
      sub_q     <= 1'b0;
      wcnt      <= '0;
      hi_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            if (area_hit) begin
              st      <= S_ADDR;
              tim     <= sel_timing;
              addr_q  <= req_word ? {req_addr[AW-1:1], 1'b0} : req_addr;
              write_q <= req_write;
              word_q  <= req_word;
              wdata_q <= req_wdata;
              sub_q   <= 1'b0;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
            end
          end
        end
        S_ADDR:   st <= tim.awt ? S_AWAIT : (tim.three ? S_DSTART : S_DEND);
        S_AWAIT:  st <= tim.three ? S_DSTART : S_DEND;
        S_DSTART: begin
          if (tim.dwt != 2'd0) begin
            st   <= S_DWAIT;
            wcnt <= tim.dwt;
          end else begin
            st <= S_DEND;
          end
        end
        S_DWAIT: begin
          if (wcnt == 2'd1) begin
            if (!(tim.ext_en && ext_wait)) st <= S_DEND;
          end else begin
            wcnt <= wcnt - 2'd1;
          end
        end
        S_DEND: begin
          if (split && !sub_q) begin
            sub_q <= 1'b1;
            hi_q  <= lane_pick[H-1:0];
            st    <= S_ADDR;
          end else begin
            st        <= S_IDLE;
            rsp_valid <= 1'b1;
            if (write_q)    rsp_rdata <= '0;
            else if (split) rsp_rdata <= {hi_q, lane_pick[H-1:0]};
            else            rsp_rdata <= lane_pick;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_data   = (st == S_DSTART) || (st == S_DWAIT) || (st == S_DEND);
  assign as_o      = (st == S_ADDR) || (st == S_AWAIT);
  assign rd_o      = in_data && !write_q;
  assign wr_o      = in_data && write_q;
  assign oe_o      = as_o || wr_o;
  assign req_ready = (st == S_IDLE);
  assign bus_addr  = {addr_q[AW-1:1], addr_q[0] | sub_q};
  assign cur_word  = word_q;
  assign cur_wide  = tim.wide;
  assign cur_sub   = sub_q;
  assign cur_wdata = wdata_q;

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int NUM_AREAS = 3,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic                          req_write,
  input  logic                          req_word,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic                          rsp_err,
  output logic [DATA_W-1:0]             rsp_rdata,
  input  logic [NUM_AREAS*ADDR_W-1:0]   cfg_base,
  input  logic [NUM_AREAS*ADDR_W-1:0]   cfg_mask,
  input  logic [NUM_AREAS-1:0]          cfg_wide,
  input  logic [NUM_AREAS-1:0]          cfg_three,
  input  logic [2*NUM_AREAS-1:0]        cfg_wmode,
  input  logic [NUM_AREAS-1:0]          cfg_awt,
  input  logic [2*NUM_AREAS-1:0]        cfg_dwt,
  output logic [DATA_W-1:0]             bus_ad_out,
  output logic                          bus_ad_oe,
  input  logic [DATA_W-1:0]             bus_ad_in,
  output logic                          bus_as,
  output logic                          bus_rd,
  output logic                          bus_wr,
  input  logic                          bus_ext_wait
);

  localparam int IDX_W = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1;

  area_cfg_t         area_cfg [NUM_AREAS];
  logic              area_hit;
  logic [IDX_W-1:0]  area_idx;
  area_cfg_t         sel_cfg;
  eff_timing_t       sel_timing;
  logic [ADDR_W-1:0] bus_addr;
  logic              cur_word;
  logic              cur_wide;
  logic              cur_sub;
  logic [DATA_W-1:0] cur_wdata;
  logic [DATA_W-1:0] lane_drive;
  logic [DATA_W-1:0] lane_pick;

  generate
    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cfg
      assign area_cfg[g].wide  = cfg_wide[g];
      assign area_cfg[g].three = cfg_three[g];
      assign area_cfg[g].wmode = cfg_wmode[2*g +: 2];
      assign area_cfg[g].awt   = cfg_awt[g];
      assign area_cfg[g].dwt   = cfg_dwt[2*g +: 2];
    end
  endgenerate

  mbc_area_decode #(
    .N  (NUM_AREAS),
    .AW (ADDR_W),
    .IW (IDX_W)
  ) u_decode (
    .addr (req_addr),
    .base (cfg_base),
    .mask (cfg_mask),
    .hit  (area_hit),
    .idx  (area_idx)
  );

  assign sel_cfg    = area_cfg[area_idx];
  assign sel_timing = resolve_timing(sel_cfg);

  mbc_cycle_seq #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_word   (req_word),
    .req_wdata  (req_wdata),
    .area_hit   (area_hit),
    .sel_timing (sel_timing),
    .ext_wait   (bus_ext_wait),
    .lane_pick  (lane_pick),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .bus_addr   (bus_addr),
    .cur_word   (cur_word),
    .cur_wide   (cur_wide),
    .cur_sub    (cur_sub),
    .cur_wdata  (cur_wdata),
    .as_o       (bus_as),
    .rd_o       (bus_rd),
    .wr_o       (bus_wr),
    .oe_o       (bus_ad_oe)
  );

  mbc_lane_map #(
    .DW (DATA_W)
  ) u_lanes (
    .wide   (cur_wide),
    .word   (cur_word),
    .sub    (cur_sub),
    .a0     (bus_addr[0]),
    .wdata  (cur_wdata),
    .bus_in (bus_ad_in),
    .drive  (lane_drive),
    .pick   (lane_pick)
  );

  always_comb begin
    if (bus_as)      bus_ad_out = DATA_W'(bus_addr);
    else if (bus_wr) bus_ad_out = lane_drive;
    else             bus_ad_out = '0;
  end

endmodule

// File: rtl/mbc_checker.sv
module mbc_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_err,
  input logic bus_as,
  input logic bus_rd,
  input logic bus_wr,
  input logic bus_ad_oe
);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_as_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |-> (!bus_rd && !bus_wr));

  assert_data_follows_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as) |-> (bus_rd || bus_wr));

  assert_read_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !bus_ad_oe);

  assert_write_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_ad_oe);

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as || bus_rd || bus_wr) |-> !req_ready);

  assert_rsp_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  assert_rsp_after_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> $past(bus_rd || bus_wr));

  assert_miss_response_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && $past(req_valid && req_ready)));

endmodule

bind mux_bus_ctrl mbc_checker u_mbc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .bus_as    (bus_as),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_ad_oe (bus_ad_oe)
);

// File: tb/test_mux_bus_ctrl.sv
module test_mux_bus_ctrl;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        as_e, rd_e, wr_e, oe_e, rdy_e, rv_e, re_e;
    logic [15:0] ad_e;
    logic [15:0] rdat_e;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [47:0] cfg_base, cfg_mask;
  logic [2:0]  cfg_wide, cfg_three, cfg_awt;
  logic [5:0]  cfg_wmode, cfg_dwt;
  logic [15:0] bus_ad_out, bus_ad_in;
  logic        bus_ad_oe, bus_as, bus_rd, bus_wr;
  logic        bus_ext_wait = 1'b0;

  logic [15:0] b_base [3];
  logic [15:0] b_mask [3];
  logic        b_wide [3];
  logic        b_three[3];
  logic [1:0]  b_wm   [3];
  logic        b_awt  [3];
  logic [1:0]  b_dwt  [3];

  exp_t  expq[$];
  int    cyc = 0;
  int    ext_from = 0, ext_to = 0;
  int    checks = 0, fails = 0;
  int    mt;
  string cur_tag = "R11";
  logic [15:0] dev_lat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      cfg_base[i*16 +: 16] = b_base[i];
      cfg_mask[i*16 +: 16] = b_mask[i];
      cfg_wide[i]          = b_wide[i];
      cfg_three[i]         = b_three[i];
      cfg_wmode[2*i +: 2]  = b_wm[i];
      cfg_awt[i]           = b_awt[i];
      cfg_dwt[2*i +: 2]    = b_dwt[i];
    end
  end

  mux_bus_ctrl i_mux_bus_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_wide(cfg_wide),
    .cfg_three(cfg_three), .cfg_wmode(cfg_wmode), .cfg_awt(cfg_awt),
    .cfg_dwt(cfg_dwt), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in), .bus_as(bus_as), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ext_wait(bus_ext_wait)
  );

  // Simple external device: latches the address, returns an address-derived pattern.
  function automatic logic [15:0] dev_fn(logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] ^ 8'h3C};
  endfunction

  function automatic bit ext_at(int c);
    return (c >= ext_from) && (c < ext_to);
  endfunction

  assign bus_ad_in = dev_fn(dev_lat);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (bus_as) dev_lat <= bus_ad_out;
    bus_ext_wait <= ext_at(cyc);
  end

  function automatic void push(logic as_v, logic rd_v, logic wr_v, logic oe_v,
                               logic [15:0] ad_v);
    exp_t e;
    e.as_e = as_v; e.rd_e = rd_v; e.wr_e = wr_v; e.oe_e = oe_v; e.ad_e = ad_v;
    e.rdy_e = 1'b0; e.rv_e = 1'b0; e.re_e = 1'b0; e.rdat_e = '0;
    expq.push_back(e);
    mt++;
  endfunction

  function automatic void push_rsp(logic err, logic [15:0] rdat);
    exp_t e;
    e.as_e = 0; e.rd_e = 0; e.wr_e = 0; e.oe_e = 0; e.ad_e = '0;
    e.rdy_e = 1'b1; e.rv_e = 1'b1; e.re_e = err; e.rdat_e = rdat;
    expq.push_back(e);
    mt++;
  endfunction

  // Reference model: expands one accepted request into per-cycle expectations.
  function automatic void build(logic [15:0] a, logic w, logic wd, logic [15:0] d);
    int          idx = -1;
    logic        ew, e3;
    logic [1:0]  mode;
    int          aw, dw, nsub, tl;
    logic [15:0] base, ba, dat, got, res;
    for (int i = 0; i < 3; i++)
      if (idx < 0 && ((a ^ b_base[i]) & b_mask[i]) == 16'h0) idx = i;
    if (idx < 0) begin
      push_rsp(1'b1, 16'h0);
      return;
    end
    ew   = b_wide[idx];
    e3   = b_three[idx];
    mode = e3 ? b_wm[idx] : 2'd0;
    aw   = (mode == 2'd1 || mode == 2'd2) ? int'(b_awt[idx]) : 0;
    dw   = (mode == 2'd1 || mode == 2'd2) ? int'(b_dwt[idx]) : 0;
    nsub = (wd && !ew) ? 2 : 1;
    base = wd ? {a[15:1], 1'b0} : a;
    res  = '0;
    for (int s = 0; s < nsub; s++) begin
      ba = base | 16'(s);
      if (ew) dat = wd ? d : (ba[0] ? {8'h00, d[7:0]} : {d[7:0], 8'h00});
      else    dat = {8'h00, (wd && s == 0) ? d[15:8] : d[7:0]};
      for (int k = 0; k <= aw; k++) push(1, 0, 0, 1, ba);
      if (e3) begin
        push(0, !w, w, w, dat);
        for (int k = 0; k < dw; k++) begin
          push(0, !w, w, w, dat);
          if (k == dw - 1 && mode == 2'd2) begin
            tl = mt - 1;
            while (ext_at(tl)) begin
              push(0, !w, w, w, dat);
              tl = mt - 1;
            end
          end
        end
      end
      push(0, !w, w, w, dat);
      got = dev_fn(ba);
      if (ew && wd)  res = got;
      else if (ew)   res = {8'h00, ba[0] ? got[7:0] : got[15:8]};
      else if (nsub == 2) res = (s == 0) ? {got[7:0], 8'h00} : {res[15:8], got[7:0]};
      else           res = {8'h00, got[7:0]};
    end
    push_rsp(1'b0, w ? 16'h0 : res);
  endfunction

  task automatic do_req(input logic [15:0] a, input logic w, input logic wd,
                        input logic [15:0] d, input int eo, input int el,
                        input string tag);
    ext_from = 0; ext_to = 0;
    @(negedge clk);
    cur_tag   = tag;
    req_valid = 1'b1; req_addr = a; req_write = w; req_word = wd; req_wdata = d;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    mt = cyc;
    if (el > 0) begin
      ext_from = cyc + eo;
      ext_to   = cyc + eo + el;
    end
    build(a, w, wd, d);
    while (expq.size() != 0) @(negedge clk);
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      bit   bad;
      if (expq.size() != 0) e = expq.pop_front();
      else begin
        e.as_e = 0; e.rd_e = 0; e.wr_e = 0; e.oe_e = 0; e.ad_e = '0;
        e.rdy_e = 1; e.rv_e = 0; e.re_e = 0; e.rdat_e = '0;
      end
      checks++;
      bad = (bus_as !== e.as_e) || (bus_rd !== e.rd_e) || (bus_wr !== e.wr_e) ||
            (bus_ad_oe !== e.oe_e) || (req_ready !== e.rdy_e) ||
            (rsp_valid !== e.rv_e) || (rsp_err !== e.re_e) ||
            (e.oe_e && bus_ad_out !== e.ad_e) ||
            (e.rv_e && rsp_rdata !== e.rdat_e);
      if (bad) begin
        fails++;
        $display("FAIL %s cycle %0d: got as=%b rd=%b wr=%b oe=%b ad=%h rdy=%b rv=%b re=%b rdat=%h expected as=%b rd=%b wr=%b oe=%b ad=%h rdy=%b rv=%b re=%b rdat=%h",
                 cur_tag, cyc, bus_as, bus_rd, bus_wr, bus_ad_oe, bus_ad_out, req_ready,
                 rsp_valid, rsp_err, rsp_rdata, e.as_e, e.rd_e, e.wr_e, e.oe_e, e.ad_e,
                 e.rdy_e, e.rv_e, e.re_e, e.rdat_e);
      end
    end
  end

  function automatic void set_area(int i, logic [15:0] bs, logic [15:0] mk, logic wide,
                                   logic three, logic [1:0] wm, logic awt, logic [1:0] dwt);
    b_base[i] = bs; b_mask[i] = mk; b_wide[i] = wide; b_three[i] = three;
    b_wm[i] = wm; b_awt[i] = awt; b_dwt[i] = dwt;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    set_area(0, 16'h1000, 16'hF000, 1, 0, 2'd1, 1, 2'd3);
    set_area(1, 16'h2000, 16'hF000, 1, 1, 2'd1, 1, 2'd2);
    set_area(2, 16'h4000, 16'hC000, 0, 1, 2'd1, 0, 2'd1);
    repeat (3) @(negedge clk);
    // R11: reset state
    checks++;
    if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || bus_as !== 1'b0 ||
        bus_rd !== 1'b0 || bus_wr !== 1'b0 || bus_ad_oe !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: got rdy=%b rv=%b as=%b rd=%b wr=%b oe=%b expected 1 0 0 0 0 0",
               req_ready, rsp_valid, bus_as, bus_rd, bus_wr, bus_ad_oe);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: 2-state window ignores its wait settings
    do_req(16'h1234, 0, 1, 16'h0, 0, 0, "R2 R6 R7");
    do_req(16'h1236, 1, 1, 16'hBEEF, 0, 0, "R2 R6 R7");
    // R3: 3-state with address wait and data waits
    do_req(16'h2346, 1, 1, 16'hCAFE, 0, 0, "R3");
    // R10: odd word address is aligned
    do_req(16'h2347, 0, 1, 16'h0, 0, 0, "R10 R3");
    // R4: wait modes 0 and 3 give no waits
    set_area(1, 16'h2000, 16'hF000, 1, 1, 2'd0, 1, 2'd3);
    do_req(16'h2400, 0, 1, 16'h0, 0, 0, "R4");
    set_area(1, 16'h2000, 16'hF000, 1, 1, 2'd3, 1, 2'd3);
    do_req(16'h2402, 1, 1, 16'h1357, 0, 0, "R4");
    // R5: external wait extends the last data wait
    set_area(1, 16'h2000, 16'hF000, 1, 1, 2'd2, 0, 2'd2);
    do_req(16'h2500, 0, 1, 16'h0, 0, 6, "R5");
    do_req(16'h2502, 1, 1, 16'h2468, 3, 2, "R5");
    // R5: line ignored with no data waits, or in mode 1
    set_area(1, 16'h2000, 16'hF000, 1, 1, 2'd2, 1, 2'd0);
    do_req(16'h2504, 0, 1, 16'h0, 0, 8, "R5");
    set_area(1, 16'h2000, 16'hF000, 1, 1, 2'd1, 0, 2'd1);
    do_req(16'h2506, 0, 1, 16'h0, 0, 8, "R5");
    // R8: byte lanes in a 16-bit window
    do_req(16'h2350, 0, 0, 16'h0, 0, 0, "R8");
    do_req(16'h2351, 0, 0, 16'h0, 0, 0, "R8");
    do_req(16'h2352, 1, 0, 16'h00A7, 0, 0, "R8");
    do_req(16'h2353, 1, 0, 16'h005C, 0, 0, "R8");
    // R9: word split in an 8-bit window
    do_req(16'h4100, 0, 1, 16'h0, 0, 0, "R9");
    do_req(16'h4101, 1, 1, 16'h9A7B, 0, 0, "R9 R10");
    do_req(16'h4203, 1, 0, 16'h00E1, 0, 0, "R8");
    set_area(2, 16'h4000, 16'hC000, 0, 0, 2'd1, 1, 2'd3);
    do_req(16'h4300, 0, 1, 16'h0, 0, 0, "R9 R2");
    // R1: miss, and priority among overlapping windows
    do_req(16'h8000, 0, 1, 16'h0, 0, 0, "R1");
    do_req(16'h0FFF, 1, 0, 16'h0011, 0, 0, "R1");
    set_area(1, 16'h1000, 16'hF000, 1, 1, 2'd1, 1, 2'd3);
    do_req(16'h1500, 0, 1, 16'h0, 0, 0, "R1");
    // R12: settings captured at acceptance
    set_area(1, 16'h2000, 16'hF000, 1, 1, 2'd1, 1, 2'd3);
    fork
      do_req(16'h2600, 0, 1, 16'h0, 0, 0, "R12");
      begin
        repeat (2) @(negedge clk);
        set_area(1, 16'h2000, 16'hF000, 0, 0, 2'd0, 0, 2'd0);
      end
    join
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule